// File: doc/BRIEF.md
# Buffered PWM Channel Bank with Timer Selection

This block holds a small bank of pulse-width-modulated output channels. Each channel compares a 10-bit duty value against an extended count. That count is formed from an 8-bit period timer plus two low-order sub-tick bits. The timers are shared and sit outside the block. The block receives each timer's extended count and a one-cycle wrap pulse. The wrap pulse is raised in the last tick of every period. Each channel chooses one of the timers through a 2-bit select code, so several channels can run at one frequency with different duties.

Software writes a control byte, two duty bytes and a select byte per channel through a simple write port. The 10-bit duty may be packed into the 16-bit byte pair as left-aligned or right-aligned data. Duty writes land in shadow bytes. The decoded value moves into the active compare register only when the selected timer wraps, so a period is never cut short or stretched by a write. A registered read port returns any of the four bytes. The control byte also carries the live output level.

Top module: `pwm_tsel_bank`

## Requirements
- R1: After a synchronous reset, every output is 0 and every register byte of every channel reads back as 0.
- R2: Control byte layout: bit 7 is enable, bit 4 is format, bits 3:0 are the mode, and mode 1111 selects PWM. Bits 6 and 5 ignore writes. On a read, bit 6 is 0 and bit 5 is the output level. Register addresses are 0 control, 1 duty low byte, 2 duty high byte, 3 timer select (bits 1:0).
- R3: While active, the output in cycle m+1 is high exactly when cycle m belongs to a started period and the extended count in cycle m is below the active duty. A period starts in the cycle after the selected wrap pulse. The output therefore rises two cycles after the wrap pulse and stays high for duty cycles of each period.
- R4: A cleared enable, a mode other than 1111 or select code 00 drives the output low from the next cycle. After the channel becomes active again, the output stays low until the next period of the selected timer begins.
- R5: With format 1, the duty is {high byte, low byte bits 7:6}.
- R6: With format 0, the duty is {high byte bits 1:0, low byte}.
- R7: The active duty changes only at a wrap pulse of the selected timer. A duty write made mid-period, or in the very cycle of the wrap pulse, first takes effect in the following period.
- R8: A duty of 4*(period+1) or more keeps the output high through whole periods. A duty of 0 keeps it low.
- R9: Select code 01 takes timer 0, 10 takes timer 1 and 11 takes timer 2. Timer k occupies bits [10k+9:10k] of tmr_ext and bit k of tmr_wrap.
- R10: Channels sharing one timer start their periods in the same cycle and keep independent duties.
- R11: rd_data shows the addressed byte one cycle after rd_ch and rd_addr are applied. Its bit 5 equals the channel's output in the cycle the address was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel written |
| wr_addr | input | 2 | Byte address written |
| wr_data | input | 8 | Write data |
| rd_ch | input | CH_W | Channel read |
| rd_addr | input | 2 | Byte address read |
| rd_data | output | 8 | Registered read data |
| tmr_ext | input | TMR_N*EXT_W | Extended counts of the shared timers |
| tmr_wrap | input | TMR_N | Wrap pulses, high in each timer's last tick |
| pwm_out | output | NCH | Channel outputs |

## Verification
Two functions can meet in one clock edge. One is the shadow write of a duty byte. The other is the reload of the active duty on the selected timer's wrap pulse. The bench waits until it sees the wrap pulse high and then drives a duty write within that same cycle. It judges the outcome by counting high cycles over the next two periods. The old duty must govern the next period, and the new duty the one after it. A cycle-by-cycle reference model in the scoreboard also covers mid-period writes and reactivation in the middle of a period.

// File: rtl/pwm_pkg.sv
`timescale 1ns / 1ps
package pwm_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DLO  = 2'd1,
    REG_DHI  = 2'd2,
    REG_TSEL = 2'd3
  } reg_addr_e;

  localparam int          CTRL_EN_BIT   = 7;
  localparam int          CTRL_STAT_BIT = 5;
  localparam int          CTRL_FMT_BIT  = 4;
  localparam logic [3:0]  MODE_PWM      = 4'hF;

  typedef struct packed {
    logic       en;
    logic       fmt;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/pwm_chan_regs.sv
`timescale 1ns / 1ps
module pwm_chan_regs
  import pwm_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [7:0]       data,
  output ctrl_t            ctrl,
  output logic [7:0]       dlo,
  output logic [7:0]       dhi,
  output logic [SEL_W-1:0] tsel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      dlo  <= '0;
      dhi  <= '0;
      tsel <= '0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        REG_CTRL: begin
          ctrl.en   <= data[CTRL_EN_BIT];
          ctrl.fmt  <= data[CTRL_FMT_BIT];
          ctrl.mode <= data[3:0];
        end
        REG_DLO:  dlo  <= data;
        REG_DHI:  dhi  <= data;
        REG_TSEL: tsel <= data[SEL_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_tmr_pick.sv
`timescale 1ns / 1ps
module pwm_tmr_pick #(
  parameter int TMR_N = 3,
  parameter int EXT_W = 10,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0]       tsel,
  input  logic [TMR_N*EXT_W-1:0] tmr_ext,
  input  logic [TMR_N-1:0]       tmr_wrap,
  output logic [EXT_W-1:0]       ext,
  output logic                   wrap,
  output logic                   valid
);
  // Code 0 is reserved; code k+1 picks timer k.
  logic [TMR_N-1:0] hit;

  for (genvar t = 0; t < TMR_N; t++) begin : g_hit
    assign hit[t] = (tsel == SEL_W'(t + 1));
  end

  always_comb begin
    ext   = '0;
    wrap  = 1'b0;
    valid = 1'b0;
    for (int t = 0; t < TMR_N; t++) begin
      if (hit[t]) begin
        ext   = tmr_ext[t*EXT_W +: EXT_W];
        wrap  = tmr_wrap[t];
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_duty_core.sv
`timescale 1ns / 1ps
module pwm_duty_core #(
  parameter int EXT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             wrap,
  input  logic [EXT_W-1:0] ext,
  input  logic             fmt,
  input  logic [7:0]       dlo,
  input  logic [7:0]       dhi,
  output logic             pwm_q,
  output logic             first_q,
  output logic [EXT_W-1:0] duty_act
);
  localparam int PAIR_W = 16;

  logic [PAIR_W-1:0] pair;
  logic [EXT_W-1:0]  duty_dec;

  assign pair     = {dhi, dlo};
  assign duty_dec = fmt ? pair[PAIR_W-1 -: EXT_W] : pair[EXT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      first_q  <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      if (wrap) duty_act <= duty_dec;
      first_q <= wrap & act;
      if (!act)                  pwm_q <= 1'b0;
      else if (first_q)          pwm_q <= (duty_act != '0);
      else if (ext == duty_act)  pwm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_tsel_bank.sv
`timescale 1ns / 1ps
module pwm_tsel_bank
  import pwm_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int TMR_N = 3,
  parameter int CNT_W = 8,
  parameter int SUB_W = 2,
  localparam int EXT_W = CNT_W + SUB_W,
  localparam int SEL_W = $clog2(TMR_N + 1),
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic [1:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [CH_W-1:0]        rd_ch,
  input  logic [1:0]             rd_addr,
  output logic [7:0]             rd_data,
  input  logic [TMR_N*EXT_W-1:0] tmr_ext,
  input  logic [TMR_N-1:0]       tmr_wrap,
  output logic [NCH-1:0]         pwm_out
);
  localparam int RB_N = 2 ** CH_W;

  logic [NCH-1:0]            ch_act;
  logic [NCH-1:0]            ch_wrap;
  logic [NCH-1:0]            ch_first;
  logic [NCH-1:0][EXT_W-1:0] ch_ext;
  logic [NCH-1:0][EXT_W-1:0] ch_duty;
  logic [7:0]                rbyte [RB_N];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ctrl_t            ctrl_c;
    logic [7:0]       dlo_c;
    logic [7:0]       dhi_c;
    logic [SEL_W-1:0] tsel_c;
    logic             valid_c;
    logic [7:0]       byte_c;

    pwm_chan_regs #(.SEL_W(SEL_W)) u_regs (
      .clk  (clk),
      .rst  (rst),
      .wr   (wr_en && (wr_ch == CH_W'(c))),
      .addr (wr_addr),
      .data (wr_data),
      .ctrl (ctrl_c),
      .dlo  (dlo_c),
      .dhi  (dhi_c),
      .tsel (tsel_c)
    );

    pwm_tmr_pick #(.TMR_N(TMR_N), .EXT_W(EXT_W), .SEL_W(SEL_W)) u_pick (
      .tsel     (tsel_c),
      .tmr_ext  (tmr_ext),
      .tmr_wrap (tmr_wrap),
      .ext      (ch_ext[c]),
      .wrap     (ch_wrap[c]),
      .valid    (valid_c)
    );

    assign ch_act[c] = ctrl_c.en && (ctrl_c.mode == MODE_PWM) && valid_c;

    pwm_duty_core #(.EXT_W(EXT_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .act      (ch_act[c]),
      .wrap     (ch_wrap[c]),
      .ext      (ch_ext[c]),
      .fmt      (ctrl_c.fmt),
      .dlo      (dlo_c),
      .dhi      (dhi_c),
      .pwm_q    (pwm_out[c]),
      .first_q  (ch_first[c]),
      .duty_act (ch_duty[c])
    );

    always_comb begin
      case (reg_addr_e'(rd_addr))
        REG_CTRL: byte_c = {ctrl_c.en, 1'b0, pwm_out[c], ctrl_c.fmt, ctrl_c.mode};
        REG_DLO:  byte_c = dlo_c;
        REG_DHI:  byte_c = dhi_c;
        default:  byte_c = {{(8-SEL_W){1'b0}}, tsel_c};
      endcase
    end

    assign rbyte[c] = byte_c;
  end

  for (genvar c = NCH; c < RB_N; c++) begin : g_pad
    assign rbyte[c] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= rbyte[rd_ch];
  end
endmodule

// File: rtl/pwm_tsel_bank_chk.sv
`timescale 1ns / 1ps
module pwm_tsel_bank_chk #(
  parameter int NCH   = 2,
  parameter int EXT_W = 10,
  parameter int CH_W  = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NCH-1:0]         act,
  input logic [NCH-1:0]         wrap_sel,
  input logic [NCH-1:0]         first,
  input logic [NCH-1:0][EXT_W-1:0] ext_sel,
  input logic [NCH-1:0][EXT_W-1:0] duty_act,
  input logic [NCH-1:0]         pwm_out,
  input logic [CH_W-1:0]        rd_ch,
  input logic [1:0]             rd_addr,
  input logic [7:0]             rd_data
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
      !act[c] |=> !pwm_out[c]);

    assert_rise_after_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out[c]) |-> $past(wrap_sel[c], 2));

    assert_fall_cause_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm_out[c]) |-> $past(!act[c] || first[c] || (ext_sel[c] == duty_act[c])));

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !wrap_sel[c] |=> $stable(duty_act[c]));

    assert_status_read_R11: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == 2'd0 && rd_ch == CH_W'(c)) |=>
        (rd_data[5] == $past(pwm_out[c]) && !rd_data[6]));
  end
endmodule

bind pwm_tsel_bank pwm_tsel_bank_chk #(.NCH(NCH), .EXT_W(EXT_W), .CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .act      (ch_act),
  .wrap_sel (ch_wrap),
  .first    (ch_first),
  .ext_sel  (ch_ext),
  .duty_act (ch_duty),
  .pwm_out  (pwm_out),
  .rd_ch    (rd_ch),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/pwm_tsel_bank_test.sv
`timescale 1ns / 1ps
module pwm_tsel_bank_test;
  localparam int NCH = 2;
  localparam int TN  = 3;
  localparam int EW  = 10;
  localparam int PER [TN] = '{9, 4, 78};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [0:0]     wr_ch = '0;
  logic [1:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [0:0]     rd_ch = '0;
  logic [1:0]     rd_addr = '0;
  logic [7:0]     rd_data;
  logic [TN*EW-1:0] tmr_ext;
  logic [TN-1:0]  tmr_wrap;
  logic [NCH-1:0] pwm_out;

  int    checks = 0;
  int    errs   = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pwm_tsel_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_ext(tmr_ext), .tmr_wrap(tmr_wrap), .pwm_out(pwm_out)
  );

  // Shared period timers: one sub-tick per clock.
  logic [7:0] tcnt [TN];
  logic [1:0] tsub [TN];
  for (genvar t = 0; t < TN; t++) begin : g_tmr
    always @(posedge clk) begin
      if (rst) begin
        tcnt[t] <= '0; tsub[t] <= '0;
      end else if (tsub[t] == 2'd3) begin
        tsub[t] <= '0;
        tcnt[t] <= (tcnt[t] == 8'(PER[t])) ? 8'd0 : tcnt[t] + 8'd1;
      end else begin
        tsub[t] <= tsub[t] + 2'd1;
      end
    end
    assign tmr_ext[t*EW +: EW] = {tcnt[t], tsub[t]};
    assign tmr_wrap[t] = (tcnt[t] == 8'(PER[t])) && (tsub[t] == 2'd3);
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // Scoreboard reference model.
  logic [7:0] ctrl_m [NCH];
  logic [7:0] dlo_m [NCH];
  logic [7:0] dhi_m [NCH];
  logic [1:0] sel_m [NCH];
  logic [9:0] dact_m [NCH];
  logic [NCH-1:0] first_m, armed_m;
  logic [NCH-1:0] expq [$];

  function automatic logic [9:0] dec(input logic [7:0] c, input logic [7:0] hi, input logic [7:0] lo);
    if (c[4]) return {hi, lo[7:6]};
    else      return {hi[1:0], lo};
  endfunction

  always @(posedge clk) begin
    logic [NCH-1:0] nxt;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        ctrl_m[c] = 0; dlo_m[c] = 0; dhi_m[c] = 0; sel_m[c] = 0; dact_m[c] = 0;
      end
      first_m = '0; armed_m = '0;
      expq.delete();
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit vld, a, w;
        int t;
        logic [9:0] e;
        vld = (sel_m[c] != 2'd0);
        t   = vld ? int'(sel_m[c]) - 1 : 0;
        e   = {tcnt[t], tsub[t]};
        w   = vld && (tcnt[t] == 8'(PER[t])) && (tsub[t] == 2'd3);
        a   = ctrl_m[c][7] && (ctrl_m[c][3:0] == 4'hF) && vld;
        nxt[c]     = a && (first_m[c] || armed_m[c]) && (e < dact_m[c]);
        armed_m[c] = a && (armed_m[c] || first_m[c]);
        first_m[c] = a && w;
        if (w) dact_m[c] = dec(ctrl_m[c], dhi_m[c], dlo_m[c]);
        if (wr_en && int'(wr_ch) == c) begin
          case (wr_addr)
            2'd0: ctrl_m[c] = wr_data & 8'h9F;
            2'd1: dlo_m[c]  = wr_data;
            2'd2: dhi_m[c]  = wr_data;
            default: sel_m[c] = wr_data[1:0];
          endcase
        end
      end
      expq.push_back(nxt);
    end
  end

  // Monitor: compares every output cycle against the model (current phase requirement).
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [NCH-1:0] ev;
      ev = expq.pop_front();
      chk(pwm_out == ev, cur_req, int'(pwm_out), int'(ev));
    end
  end

  task automatic wr(input int ch, input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 1'(ch); wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_now(input int ch, input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_ch = 1'(ch); wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int a, output logic [7:0] d, output logic prev);
    @(negedge clk);
    rd_ch = 1'(ch); rd_addr = 2'(a);
    prev = pwm_out[ch];
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_wrap(input int t);
    do @(negedge clk); while (!tmr_wrap[t]);
  endtask

  task automatic count_from_here(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
  endtask

  task automatic measure(input int ch, input int t, output int hi);
    wait_wrap(t);
    @(negedge clk);
    count_from_here(ch, 4 * (PER[t] + 1), hi);
  endtask

  initial begin
    logic [7:0] d;
    logic       p;
    int         n;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    chk(pwm_out == '0, "R1 outputs", int'(pwm_out), 0);
    rd(0, 0, d, p); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(1, 3, d, p); chk(d == 8'h00, "R1 tsel", d, 0);
    rd(1, 2, d, p); chk(d == 8'h00, "R1 dhi", d, 0);

    // R2 / R5 / R9: left-aligned duty 9 on timer 0 (period 40)
    cur_req = "R5";
    wr(0, 3, 8'h01); wr(0, 2, 8'h02); wr(0, 1, 8'h40); wr(0, 0, 8'hFF);
    rd(0, 0, d, p);
    chk((d & 8'hDF) == 8'h9F, "R2 ctrl readback", d & 8'hDF, 8'h9F);
    chk(d[5] == p, "R11 status bit", d[5], p);
    wait_wrap(0);
    measure(0, 0, n); chk(n == 9, "R5 left-aligned high count", n, 9);
    chk(n == 9, "R9 code 01 selects timer 0", n, 9);

    // R3: rise two cycles after wrap
    cur_req = "R3";
    wait_wrap(0);
    @(negedge clk); chk(pwm_out[0] == 1'b0, "R3 low one cycle after wrap", pwm_out[0], 0);
    @(negedge clk); chk(pwm_out[0] == 1'b1, "R3 high two cycles after wrap", pwm_out[0], 1);

    // R6: right-aligned on timer 1 (period 20), then timer 2 (period 316)
    cur_req = "R6";
    wr(1, 3, 8'h02); wr(1, 2, 8'h00); wr(1, 1, 8'h07); wr(1, 0, 8'h8F);
    wait_wrap(1);
    measure(1, 1, n); chk(n == 7, "R6 right-aligned count", n, 7);
    chk(n == 7, "R9 code 10 selects timer 1", n, 7);
    wr(1, 0, 8'h0F); wr(1, 3, 8'h03); wr(1, 2, 8'h01); wr(1, 1, 8'h05); wr(1, 0, 8'h8F);
    wait_wrap(2);
    measure(1, 2, n); chk(n == 261, "R6 right-aligned upper bits", n, 261);
    chk(n == 261, "R9 code 11 selects timer 2", n, 261);

    // R8: full and zero duty; R11 status while high
    cur_req = "R8";
    wr(0, 2, 8'h0A); wr(0, 1, 8'h00);
    wait_wrap(0);
    measure(0, 0, n); chk(n == 40, "R8 full duty", n, 40);
    rd(0, 0, d, p);
    chk(p == 1'b1 && d[5] == 1'b1, "R11 status while high", d[5], 1);
    wr(0, 2, 8'h00);
    wait_wrap(0);
    measure(0, 0, n); chk(n == 0, "R8 zero duty", n, 0);
    rd(0, 0, d, p);
    chk(d[5] == 1'b0, "R11 status while low", d[5], 0);

    // R4: inactive conditions
    cur_req = "R4";
    wr(0, 2, 8'h02); wr(0, 1, 8'h40);
    wait_wrap(0); wait_wrap(0);
    wr(0, 0, 8'h1F);
    measure(0, 0, n); chk(n == 0, "R4 enable cleared", n, 0);
    wr(0, 0, 8'h9E);
    measure(0, 0, n); chk(n == 0, "R4 mode not PWM", n, 0);
    wr(0, 0, 8'h9F); wr(0, 3, 8'h00);
    measure(0, 0, n); chk(n == 0, "R4 reserved select", n, 0);
    wait_wrap(0);
    repeat (10) @(negedge clk);
    wr(0, 3, 8'h01);
    count_from_here(0, 8, n); chk(n == 0, "R4 low until next period", n, 0);
    measure(0, 0, n); chk(n == 9, "R4 resumes after period start", n, 9);

    // R10: both channels share timer 2
    cur_req = "R10";
    wr(0, 0, 8'h1F); wr(0, 3, 8'h03); wr(0, 2, 8'd78); wr(0, 1, 8'h00); wr(0, 0, 8'h9F);
    wr(1, 0, 8'h1F); wr(1, 2, 8'd35); wr(1, 1, 8'h00); wr(1, 0, 8'h9F);
    wait_wrap(2); wait_wrap(2);
    @(negedge clk); @(negedge clk);
    chk(pwm_out == 2'b11, "R10 common period start", int'(pwm_out), 3);
    measure(0, 2, n); chk(n == 312, "R10 channel 0 duty", n, 312);
    measure(1, 2, n); chk(n == 140, "R10 channel 1 duty", n, 140);

    // R7: duty write in the wrap cycle is deferred one period
    cur_req = "R7";
    wr(0, 0, 8'h1F); wr(0, 3, 8'h01); wr(0, 2, 8'h02); wr(0, 1, 8'h40); wr(0, 0, 8'h9F);
    wait_wrap(0); wait_wrap(0);
    wait_wrap(0);
    wr_now(0, 2, 8'h05);
    count_from_here(0, 40, n); chk(n == 9, "R7 wrap-cycle write deferred", n, 9);
    measure(0, 0, n); chk(n == 21, "R7 new duty next period", n, 21);
    wait_wrap(0);
    repeat (5) @(negedge clk);
    wr(0, 2, 8'h02);
    wait_wrap(0);
    @(negedge clk);
    count_from_here(0, 40, n); chk(n == 9, "R7 mid-period write applied next", n, 9);

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule